// File: doc/BRIEF.md
# Time-Multiplexed PI and Lead Compensator

This block is a discrete-time loop compensator for a digital power-stage controller. Each error sample passes through a proportional-integral stage, and that stage's output then drives a first-order lead stage built in direct form II. One multiplier and one saturating adder do all of the work. A step sequencer feeds them one operation per clock, so the block needs very little arithmetic hardware. The price is a fixed latency of several cycles for each sample.

Samples enter on a valid/ready input. A sample is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high only while the block is idle. A source that raises `in_valid` while the block is busy is not stalled and is not queued: that request is dropped.

The result is offered on a valid/ready output. While `out_valid` is high and `out_ready` is low, the result is held unchanged and no new sample is taken. All coefficients and the two integrator limits are ports, and they are captured together with the sample. This means they can change at any time without disturbing a computation in progress.

Top module: `pilead_comp`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) forces `out_valid` low and `in_ready` high. It also zeroes the integrator state and the lead delay state, so the first result after reset is computed from zero history.
- R2: `in_ready` is high only while idle. It falls on the edge after a sample is taken. A request raised while `in_ready` is low is ignored: it produces no result and does not alter any state.
- R3: `out_valid` rises exactly 9 clock edges after the edge that takes the sample.
- R4: While `out_valid` is high and `out_ready` is low, `out_y` is held stable and `in_ready` stays low. On the edge where both `out_valid` and `out_ready` are high, the result is consumed. After that edge, `out_valid` is low and `in_ready` is high.
- R5: The PI stage computes I(n) = clamp(sat(I(n-1) + M(Ki,e))) and x = sat(M(Kp,e) + I(n)).
- R6: After each update, the integrator lies within [`int_lo`, `int_hi`], using the limits captured with the sample. An update above the upper limit yields exactly `int_hi`, and one below the lower limit yields exactly `int_lo`.
- R7: The lead stage computes w = sat(x - M(B0,w1)) and d = sat(w - M(A0,w1)). The output is y = M(K0,d), and then w1 takes the value w.
- R8: Coefficients are signed Q-format values with FRAC fractional bits (default 12, so 4096 means 1.0). M(c,v) = (c*v + 2^(FRAC-1)) >>> FRAC, saturated to the DW-bit signed range.
- R9: Every addition and subtraction saturates to the DW-bit signed range [-2^(DW-1), 2^(DW-1)-1] instead of wrapping.
- R10: Coefficients and limits are captured on the sample edge. Changes on those ports during a computation have no effect on its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Error sample offered |
| in_ready | output | 1 | Block idle, sample may be taken |
| in_err | input | DW | Signed error sample |
| kp | input | CW | Proportional gain, Q format |
| ki | input | CW | Integral gain, Q format |
| k0 | input | CW | Lead output gain, Q format |
| a0 | input | CW | Lead zero coefficient, Q format |
| b0 | input | CW | Lead pole coefficient, Q format |
| int_hi | input | DW | Integrator upper limit |
| int_lo | input | DW | Integrator lower limit |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer accepts result |
| out_y | output | DW | Signed compensator output |

## Verification
The hardest case to reach from the ports is one where hidden history decides the result. That covers both the integrator pinned at a limit and the lead delay state carried across samples. The bench drives a unit-gain path in which the output equals the integrator, then walks the integrator through both limits and reads each clamped value directly at `out_y`. A request pulsed in the middle of a computation, together with coefficient ports changed in the middle of a run, must leave every later result equal to the reference model. This shows that neither event reached the internal state.

// File: rtl/pilead_pkg.sv
package pilead_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_KI,
    ST_INT,
    ST_KP,
    ST_SUMX,
    ST_B0,
    ST_W,
    ST_A0,
    ST_D,
    ST_K0,
    ST_DONE
  } step_e;

  // edges from sample capture to result valid
  localparam int unsigned STEP_COUNT = 9;

  localparam int unsigned NCOEF = 5;
  localparam int unsigned C_KP = 0;
  localparam int unsigned C_KI = 1;
  localparam int unsigned C_K0 = 2;
  localparam int unsigned C_A0 = 3;
  localparam int unsigned C_B0 = 4;
endpackage

// File: rtl/pilead_mul.sv
// Shared multiplier: signed product, round half up, shift, saturate.
module pilead_mul #(
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int FRAC = 12
) (
  input  logic signed [DW-1:0] din,
  input  logic signed [CW-1:0] coef,
  output logic signed [DW-1:0] prod
);
  localparam int PW = DW + CW;

  logic signed [PW-1:0] full;
  logic signed [PW-1:0] shifted;
  logic                 fits;

  assign full = PW'(din) * PW'(coef);

  generate
    if (FRAC > 0) begin : g_round
      logic signed [PW-1:0] biased;
      assign biased  = full + (PW'(1) <<< (FRAC - 1));
      assign shifted = biased >>> FRAC;
    end else begin : g_noround
      assign shifted = full;
    end
  endgenerate

  assign fits = (shifted[PW-1:DW-1] == '0) || (shifted[PW-1:DW-1] == '1);

  always_comb begin
    if (fits) prod = shifted[DW-1:0];
    else      prod = {shifted[PW-1], {(DW-1){~shifted[PW-1]}}};
  end
endmodule

// File: rtl/pilead_add.sv
// Shared adder/subtractor with saturation.
module pilead_add #(
  parameter int DW = 16
) (
  input  logic signed [DW-1:0] a,
  input  logic signed [DW-1:0] b,
  input  logic                 sub,
  output logic signed [DW-1:0] sum
);
  logic [DW:0] ext;

  always_comb begin
    if (sub) ext = {a[DW-1], a} - {b[DW-1], b};
    else     ext = {a[DW-1], a} + {b[DW-1], b};
    if (ext[DW] != ext[DW-1]) sum = {ext[DW], {(DW-1){~ext[DW]}}};
    else                      sum = ext[DW-1:0];
  end
endmodule

// File: rtl/pilead_seq.sv
// Step sequencer: one arithmetic operation per state.
module pilead_seq
  import pilead_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  in_valid,
  input  logic  out_ready,
  output step_e state,
  output logic  in_ready,
  output logic  out_valid,
  output logic  accept
);
  step_e nxt;

  assign in_ready  = (state == ST_IDLE);
  assign out_valid = (state == ST_DONE);
  assign accept    = in_ready && in_valid;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: if (in_valid) nxt = ST_KI;
      ST_KI:   nxt = ST_INT;
      ST_INT:  nxt = ST_KP;
      ST_KP:   nxt = ST_SUMX;
      ST_SUMX: nxt = ST_B0;
      ST_B0:   nxt = ST_W;
      ST_W:    nxt = ST_A0;
      ST_A0:   nxt = ST_D;
      ST_D:    nxt = ST_K0;
      ST_K0:   nxt = ST_DONE;
      ST_DONE: if (out_ready) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nxt;
  end
endmodule

// File: rtl/pilead_comp.sv
// PI followed by direct-form-II lead, sharing one multiplier and one adder.
module pilead_comp
  import pilead_pkg::*;
#(
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int FRAC = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [DW-1:0] in_err,
  input  logic signed [CW-1:0] kp,
  input  logic signed [CW-1:0] ki,
  input  logic signed [CW-1:0] k0,
  input  logic signed [CW-1:0] a0,
  input  logic signed [CW-1:0] b0,
  input  logic signed [DW-1:0] int_hi,
  input  logic signed [DW-1:0] int_lo,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic signed [DW-1:0] out_y
);
  step_e state;
  logic  accept;

  logic signed [CW-1:0] coef_in [NCOEF];
  logic signed [CW-1:0] coef_q  [NCOEF];
  logic signed [DW-1:0] err_q, hi_q, lo_q;
  logic signed [DW-1:0] m_q;     // product register
  logic signed [DW-1:0] integ;   // integrator state
  logic signed [DW-1:0] acc;     // x, then w, then d
  logic signed [DW-1:0] w1;      // lead unit delay

  logic signed [DW-1:0] mul_din, mul_out;
  logic signed [CW-1:0] mul_coef;
  logic signed [DW-1:0] add_a, add_b, add_out, integ_next;
  logic                 add_sub;

  assign coef_in[C_KP] = kp;
  assign coef_in[C_KI] = ki;
  assign coef_in[C_K0] = k0;
  assign coef_in[C_A0] = a0;
  assign coef_in[C_B0] = b0;

  pilead_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .state     (state),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .accept    (accept)
  );

  always_comb begin
    mul_din  = err_q;
    mul_coef = coef_q[C_KP];
    unique case (state)
      ST_KI: mul_coef = coef_q[C_KI];
      ST_B0: begin mul_din = w1;  mul_coef = coef_q[C_B0]; end
      ST_A0: begin mul_din = w1;  mul_coef = coef_q[C_A0]; end
      ST_K0: begin mul_din = acc; mul_coef = coef_q[C_K0]; end
      default: ;
    endcase
  end

  pilead_mul #(.DW(DW), .CW(CW), .FRAC(FRAC)) u_mul (
    .din  (mul_din),
    .coef (mul_coef),
    .prod (mul_out)
  );

  always_comb begin
    add_a   = acc;
    add_b   = m_q;
    add_sub = 1'b1;
    unique case (state)
      ST_INT:  begin add_a = integ; add_b = m_q;   add_sub = 1'b0; end
      ST_SUMX: begin add_a = m_q;   add_b = integ; add_sub = 1'b0; end
      default: ;
    endcase
  end

  pilead_add #(.DW(DW)) u_add (
    .a   (add_a),
    .b   (add_b),
    .sub (add_sub),
    .sum (add_out)
  );

  always_comb begin
    if (add_out > hi_q)      integ_next = hi_q;
    else if (add_out < lo_q) integ_next = lo_q;
    else                     integ_next = add_out;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q <= '0;
      hi_q  <= '0;
      lo_q  <= '0;
      m_q   <= '0;
      integ <= '0;
      acc   <= '0;
      w1    <= '0;
      for (int i = 0; i < NCOEF; i++) coef_q[i] <= '0;
    end else begin
      if (accept) begin
        err_q <= in_err;
        hi_q  <= int_hi;
        lo_q  <= int_lo;
        for (int i = 0; i < NCOEF; i++) coef_q[i] <= coef_in[i];
      end
      unique case (state)
        ST_KI, ST_KP, ST_B0, ST_A0, ST_K0: m_q <= mul_out;
        ST_INT:        integ <= integ_next;
        ST_SUMX, ST_W: acc   <= add_out;
        ST_D: begin
          acc <= add_out;
          w1  <= acc;
        end
        default: ;
      endcase
    end
  end

  assign out_y = m_q;
endmodule

// File: rtl/pilead_chk.sv
module pilead_chk
  import pilead_pkg::*;
#(
  parameter int DW = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic signed [DW-1:0] out_y,
  input step_e                state,
  input logic signed [DW-1:0] integ,
  input logic signed [DW-1:0] hi_q,
  input logic signed [DW-1:0] lo_q
);
  logic       track;
  logic [4:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      track <= 1'b0;
      cnt   <= '0;
    end else if (in_valid && in_ready) begin
      track <= 1'b1;
      cnt   <= '0;
    end else if (out_valid && out_ready) begin
      track <= 1'b0;
    end else if (track && !out_valid) begin
      cnt <= cnt + 5'd1;
    end
  end

  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!out_valid && in_ready));

  a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);

  a_r2_ready_drops: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);

  a_r3_latency: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> (cnt == 5'(STEP_COUNT)));

  a_r4_hold_result: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_y)));

  a_r6_integ_in_limits: assert property (@(posedge clk) disable iff (rst)
    (state == ST_KP && lo_q <= hi_q) |-> (integ <= hi_q && integ >= lo_q));
endmodule

bind pilead_comp pilead_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_y     (out_y),
  .state     (state),
  .integ     (integ),
  .hi_q      (hi_q),
  .lo_q      (lo_q)
);

// File: tb/tb_pilead_comp.sv
`timescale 1ns/1ps
module tb_pilead_comp;
  localparam int DW = 16;
  localparam int FRAC = 12;
  localparam int LAT = 9;

  typedef struct packed {
    logic [15:0] err, kp, ki, k0, a0, b0, hi, lo;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{16'sd1000,  16'sd4096,   16'sd1024, 16'sd4096, 16'sd2048,  -16'sd1024, 16'sd20000, -16'sd20000},
    '{-16'sd500,  16'sd4096,   16'sd1024, 16'sd4096, 16'sd2048,  -16'sd1024, 16'sd20000, -16'sd20000},
    '{16'sd3000,  16'sd8192,   16'sd2048, 16'sd6144, 16'sd1024,  16'sd1024,  16'sd20000, -16'sd20000},
    '{16'sd0,     16'sd8192,   16'sd2048, 16'sd6144, 16'sd1024,  16'sd1024,  16'sd20000, -16'sd20000},
    '{16'sd20000, 16'sd16384,  16'sd8192, 16'sd8192, 16'sd0,     16'sd0,     16'sd30000, -16'sd30000},
    '{-16'sd20000,16'sd16384,  16'sd8192, 16'sd8192, 16'sd0,     16'sd0,     16'sd30000, -16'sd30000},
    '{16'sd7,     16'sd3,      16'sd5,    16'sd4096, 16'sd0,     16'sd0,     16'sd20000, -16'sd20000},
    '{-16'sd32768,-16'sd32768, 16'sd0,    16'sd4096, 16'sd4096,  -16'sd2048, 16'sd30000, -16'sd30000}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic signed [DW-1:0] in_err = '0;
  logic signed [15:0] kp = '0, ki = '0, k0 = '0, a0 = '0, b0 = '0;
  logic signed [DW-1:0] int_hi = '0, int_lo = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic signed [DW-1:0] out_y;

  int checks = 0;
  int errors = 0;
  longint mi = 0, mw1 = 0;

  always #2 clk = ~clk;

  pilead_comp dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_err(in_err),
    .kp(kp), .ki(ki), .k0(k0), .a0(a0), .b0(b0), .int_hi(int_hi), .int_lo(int_lo),
    .out_valid(out_valid), .out_ready(out_ready), .out_y(out_y)
  );

  function automatic longint sat(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic longint mq(input longint c, input longint v);
    return sat((c * v + (longint'(1) <<< (FRAC - 1))) >>> FRAC);
  endfunction

  function automatic longint model(input longint e, p, i, g, za, pb, hi, lo);
    longint t, x, w, d;
    t = sat(mi + mq(i, e));
    if (t > hi) t = hi;
    else if (t < lo) t = lo;
    mi = t;
    x = sat(mq(p, e) + mi);
    w = sat(x - mq(pb, mw1));
    d = sat(w - mq(za, mw1));
    mw1 = w;
    return mq(g, d);
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    mi = 0;
    mw1 = 0;
    chk(in_ready === 1'b1 && out_valid === 1'b0, "R1 idle after reset",
        {in_ready, out_valid}, 2'b10);
  endtask

  task automatic do_run(input int e, p, i, g, za, pb, hi, lo, input int hold,
                        input bit poke, input bit twiddle, input string tag,
                        output longint yo);
    int c;
    longint exp;
    logic signed [DW-1:0] held;
    @(negedge clk);
    in_err = DW'(e); kp = 16'(p); ki = 16'(i); k0 = 16'(g);
    a0 = 16'(za); b0 = 16'(pb); int_hi = DW'(hi); int_lo = DW'(lo);
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    c = 0;
    while (!out_valid && c < 40) begin
      if (c == 1 && twiddle) begin
        kp = 16'sd12345; ki = -16'sd7000; k0 = 16'sd100; a0 = 16'sd999; b0 = -16'sd999;
        int_hi = 16'sd5; int_lo = -16'sd5;
      end
      if (c == 2) begin
        chk(in_ready === 1'b0, "R2 not ready while busy", in_ready, 0);
        if (poke) begin in_valid = 1'b1; in_err = 16'sd12345; end
      end
      if (c == 3) in_valid = 1'b0;
      @(negedge clk);
      c++;
    end
    chk(c == LAT, "R3 latency", c, LAT);
    exp = model(e, p, i, g, za, pb, hi, lo);
    yo = out_y;
    chk(out_y == exp, tag, out_y, exp);
    held = out_y;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      chk(out_valid === 1'b1 && out_y == held && in_ready === 1'b0, "R4 held under back-pressure",
          out_y, held);
    end
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
    chk(out_valid === 1'b0 && in_ready === 1'b1, "R4 consumed then idle",
        {out_valid, in_ready}, 2'b01);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    longint y;
    bit seen;
    @(negedge clk);
    do_reset();

    // table walk: R5 R7 R8 R9 chained through integrator and lead state
    for (int v = 0; v < NV; v++) begin
      do_run($signed(VECS[v].err), $signed(VECS[v].kp), $signed(VECS[v].ki),
             $signed(VECS[v].k0), $signed(VECS[v].a0), $signed(VECS[v].b0),
             $signed(VECS[v].hi), $signed(VECS[v].lo), 0, 1'b0, 1'b0,
             "R5 R7 R8 R9 table result", y);
    end

    // R4: back-pressure hold for several cycles
    do_run(1234, 4096, 512, 4096, 1024, 512, 20000, -20000, 6, 1'b0, 1'b0, "R4 result", y);

    // R2: request during busy is ignored, no extra result appears
    do_run(-800, 4096, 1024, 4096, 0, 2048, 20000, -20000, 0, 1'b1, 1'b0, "R2 result with poke", y);
    seen = 1'b0;
    for (int k = 0; k < 14; k++) begin
      @(negedge clk);
      if (out_valid) seen = 1'b1;
    end
    chk(!seen, "R2 ignored request made no result", seen, 0);
    do_run(300, 4096, 1024, 4096, 0, 2048, 20000, -20000, 0, 1'b0, 1'b0, "R2 state untouched", y);

    // R10: coefficient ports change during a run
    do_run(2500, 6000, 3000, 5000, 1500, -700, 20000, -20000, 0, 1'b0, 1'b1, "R10 captured coefs", y);
    do_run(-100, 4096, 1000, 4096, 500, 500, 20000, -20000, 0, 1'b0, 1'b0, "R10 next result", y);

    // R6: unit path, output equals integrator
    do_reset();
    do_run(600, 0, 4096, 4096, 0, 0, 1000, -800, 0, 1'b0, 1'b0, "R6 below limit", y);
    chk(y == 600, "R6 first step", y, 600);
    do_run(600, 0, 4096, 4096, 0, 0, 1000, -800, 0, 1'b0, 1'b0, "R6 upper clamp", y);
    chk(y == 1000, "R6 upper limit value", y, 1000);
    do_run(-2000, 0, 4096, 4096, 0, 0, 1000, -800, 0, 1'b0, 1'b0, "R6 lower clamp", y);
    chk(y == -800, "R6 lower limit value", y, -800);

    // R1: reset in the middle of a computation clears state
    @(negedge clk);
    in_err = 16'sd5000; kp = 16'sd4096; ki = 16'sd4096; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
    do_reset();
    do_run(900, 4096, 2048, 4096, 1024, -1024, 20000, -20000, 0, 1'b0, 1'b0, "R1 zero history", y);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule